// File: doc/BRIEF.md
# NAND Flash Command Sequencer

This block drives a raw 8-bit NAND flash bus from a small register set. Software loads two command bytes, a low and a high address word, an optional transmit word and a timing word, then writes a command word. The command word both starts the engine (its GO bit) and picks the phases that run: a first command-latch cycle, an address-latch burst of 1 to 5 bytes, a programmed-I/O transfer of 1 to 4 bytes in either direction, and a second command-latch cycle placed before or after the data phase. Every command ends with a wait on the flash ready line.

Completion shows as the GO bit reading back as zero together with a done bit in a write-one-to-clear interrupt register; the interrupt output is the OR of the pending bits. A cycle limit on the ready wait ends a stuck command with a timeout bit instead. A status bit follows the ready line directly for polling. Received bytes land in a 32-bit response word with the first byte in bits 7:0.

Top module: `nand_seq`

## Requirements
- R1: After reset the bus is idle (command and address latches low, both strobes high, data output disabled), every readable register returns zero apart from the ready mirror, and the interrupt output is low.
- R2: Enabled phases run in the fixed order first command, address, second command (before-data form), data, second command (after-data form), ready wait; phases whose flags are clear are skipped. Command word bits: 0 GO, 1 first command, 2 address, 5:3 address count, 6 data phase, 7 receive, 9:8 transfer size, 10 second command, 11 second command after data.
- R3: The address phase sends (count field + 1) bytes, 1 to 5, taken least significant byte first from the 40-bit value formed by the low address word (offset 2) under bits 7:0 of the high address word (offset 3).
- R4: The second command byte (bits 15:8 of offset 1; the first command is bits 7:0) is sent before the data phase when bit 11 is clear and after it when bit 11 is set.
- R5: A receive transfer moves (size field + 1) bytes into the response word (offset 5), first byte in bits 7:0, unused bytes zero.
- R6: A transmit transfer sends (size field + 1) bytes of the transmit word (written at offset 5), least significant byte first.
- R7: Each write strobe stays low for (timing bits 3:0) + 1 cycles and each read strobe for (timing bits 11:8) + 1 cycles; the high widths come from bits 7:4 and 15:12.
- R8: GO reads back as 1 until the ready wait sees the ready input high; at that point GO clears and the done bit (offset 7 bit 0) is set.
- R9: Interrupt bits are cleared by writing ones to them, and the interrupt output is high whenever any bit is pending.
- R10: Bit 0 of the status register (offset 6) follows the ready input.
- R11: A write to the command word while a command is in progress has no effect.
- R12: If the ready input stays low for more than (timing bits 31:16) cycles of the wait, the command ends with the timeout bit (offset 7 bit 1) set and the done bit clear.
- R13: Command and address latches are never high together, and both strobes are never low together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, combinational on reg_addr |
| irq | output | 1 | High while any interrupt bit is pending |
| nand_cle | output | 1 | Command latch enable |
| nand_ale | output | 1 | Address latch enable |
| nand_we_n | output | 1 | Write strobe, active low |
| nand_re_n | output | 1 | Read strobe, active low |
| nand_dq_o | output | 8 | Data bus out |
| nand_dq_oe | output | 1 | Data bus output enable |
| nand_dq_i | input | 8 | Data bus in |
| nand_rdy | input | 1 | Flash ready (1) / busy (0) |

## Verification
The sequencing is tried with seven command words shaped like real flash operations: a page read with a read-start command before the data, a program with its confirm after the data, a three-byte erase, an identify read with one address byte, a status read with no address, a bare reset and an address-only burst. Comparing the latched bus log against the expected byte list tells apart phase skipping, second-command placement and address byte order, while the response word exposes byte-lane order for receive sizes of 1 and 4. Holding the ready input low separates a proper wait from early completion, from the timeout path and from a GO write accepted mid-command.

// File: rtl/nseq_pkg.sv
// Shared definitions for the NAND command sequencer: register offsets,
// command word layout and the phase encoding. Phase values are ordered
// because the sequencer compares them to skip disabled phases.
package nseq_pkg;
    localparam int REG_AW = 3;

    localparam logic [REG_AW-1:0] OFS_CTRL   = 3'd0;
    localparam logic [REG_AW-1:0] OFS_CMDS   = 3'd1;
    localparam logic [REG_AW-1:0] OFS_ADR_LO = 3'd2;
    localparam logic [REG_AW-1:0] OFS_ADR_HI = 3'd3;
    localparam logic [REG_AW-1:0] OFS_TIMING = 3'd4;
    localparam logic [REG_AW-1:0] OFS_DATA   = 3'd5;
    localparam logic [REG_AW-1:0] OFS_STATUS = 3'd6;
    localparam logic [REG_AW-1:0] OFS_IRQ    = 3'd7;

    typedef struct packed {
        logic [19:0] rsvd;
        logic        c2_after;
        logic        c2_en;
        logic [1:0]  xsize;
        logic        rx;
        logic        pio;
        logic [2:0]  alen;
        logic        ale;
        logic        cle;
        logic        go;
    } cmdword_t;

    typedef enum logic [2:0] {
        PH_IDLE  = 3'd0,
        PH_CMD1  = 3'd1,
        PH_ADDR  = 3'd2,
        PH_CMD2B = 3'd3,
        PH_DATA  = 3'd4,
        PH_CMD2A = 3'd5,
        PH_WAIT  = 3'd6
    } phase_t;

    // First enabled phase strictly after p; the ready wait closes every command.
    function automatic phase_t next_phase(phase_t p, cmdword_t c);
        if (p == PH_IDLE && c.cle) return PH_CMD1;
        if (p <= PH_CMD1 && c.ale) return PH_ADDR;
        if (p <= PH_ADDR && c.c2_en && !c.c2_after) return PH_CMD2B;
        if (p <= PH_CMD2B && c.pio) return PH_DATA;
        if (p <= PH_DATA && c.c2_en && c.c2_after) return PH_CMD2A;
        return PH_WAIT;
    endfunction
endpackage

// File: rtl/nseq_strobe.sv
// Strobe timer: on start, holds the strobe low for lo_cnt+1 cycles, then
// high for hi_cnt+1 cycles, then reports done. Assumes counts stay stable
// while a strobe runs and that start only comes while idle.
module nseq_strobe #(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [CNT_W-1:0] lo_cnt,
    input  logic [CNT_W-1:0] hi_cnt,
    output logic             low,
    output logic             sample,
    output logic             done
);
    typedef enum logic [1:0] { S_IDLE, S_LO, S_HI } stb_t;
    stb_t             state;
    logic [CNT_W-1:0] cnt;

    // Walk low then high windows, reloading the counter at each step.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= S_IDLE;
            cnt   <= '0;
        end else begin
            case (state)
                S_IDLE: if (start) begin state <= S_LO; cnt <= lo_cnt; end
                S_LO:   if (cnt == '0) begin state <= S_HI; cnt <= hi_cnt; end
                        else cnt <= cnt - 1'b1;
                S_HI:   if (cnt == '0) state <= S_IDLE;
                        else cnt <= cnt - 1'b1;
                default: state <= S_IDLE;
            endcase
        end
    end

    assign low    = (state == S_LO);
    assign sample = (state == S_LO) && (cnt == '0);
    assign done   = (state == S_HI) && (cnt == '0);

    // R7
    strobe_start_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start |-> (state == S_IDLE));
    // R7
    strobe_goes_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> low);
endmodule

// File: rtl/nseq_fsm.sv
// Phase sequencer: latches the command word on an accepted GO, steps through
// the enabled phases one byte strobe at a time, gathers received bytes and
// waits for ready with a cycle limit. Assumes software leaves the command,
// address and transmit registers unchanged while a command runs.
module nseq_fsm
    import nseq_pkg::*;
#(
    parameter int TMO_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             go_req,
    input  logic [31:0]      go_word,
    input  logic [7:0]       cmd1,
    input  logic [7:0]       cmd2,
    input  logic [31:0]      addr_lo,
    input  logic [7:0]       addr_hi,
    input  logic [31:0]      tx_word,
    input  logic [TMO_W-1:0] tmo_lim,
    input  logic             rdy,
    input  logic [7:0]       dq_i,
    input  logic             stb_sample,
    input  logic             stb_done,
    output logic             stb_start,
    output logic             stb_read,
    output logic             busy,
    output logic [31:0]      cw_out,
    output logic [31:0]      resp,
    output logic             set_done,
    output logic             set_tmo,
    output logic             cle,
    output logic             ale,
    output logic [7:0]       dq_o,
    output logic             dq_oe
);
    phase_t           phase;
    cmdword_t         cw_q;
    logic [2:0]       idx;
    logic             inflight;
    logic [TMO_W-1:0] tcnt;
    logic             byte_ph;
    logic             last_byte;
    logic [39:0]      abytes;

    assign byte_ph   = (phase != PH_IDLE) && (phase != PH_WAIT);
    assign last_byte = (phase == PH_ADDR) ? (idx == cw_q.alen)
                     : (phase == PH_DATA) ? (idx == {1'b0, cw_q.xsize}) : 1'b1;
    assign abytes    = {addr_hi, addr_lo};

    // Advance phases, count bytes, capture read data and run the ready wait.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase    <= PH_IDLE;
            cw_q     <= '0;
            idx      <= '0;
            inflight <= 1'b0;
            tcnt     <= '0;
            resp     <= '0;
        end else begin
            case (phase)
                PH_IDLE: if (go_req) begin
                    cw_q     <= cmdword_t'(go_word & ~32'h1);
                    phase    <= next_phase(PH_IDLE, cmdword_t'(go_word));
                    idx      <= '0;
                    inflight <= 1'b0;
                    tcnt     <= '0;
                    resp     <= '0;
                end
                PH_WAIT: begin
                    if (rdy || tcnt == tmo_lim) phase <= PH_IDLE;
                    else tcnt <= tcnt + 1'b1;
                end
                default: begin
                    if (stb_sample && stb_read)
                        resp[{idx[1:0], 3'b000} +: 8] <= dq_i;
                    if (!inflight) begin
                        inflight <= 1'b1;
                    end else if (stb_done) begin
                        inflight <= 1'b0;
                        if (last_byte) begin
                            idx   <= '0;
                            phase <= next_phase(phase, cw_q);
                        end else begin
                            idx <= idx + 1'b1;
                        end
                    end
                end
            endcase
        end
    end

    // Bus drive for the current phase and byte.
    always_comb begin
        cle   = (phase == PH_CMD1) || (phase == PH_CMD2B) || (phase == PH_CMD2A);
        ale   = (phase == PH_ADDR);
        dq_oe = byte_ph && !(phase == PH_DATA && cw_q.rx);
        case (phase)
            PH_CMD1:  dq_o = cmd1;
            PH_CMD2B,
            PH_CMD2A: dq_o = cmd2;
            PH_ADDR:  dq_o = abytes[{idx, 3'b000} +: 8];
            PH_DATA:  dq_o = tx_word[{idx[1:0], 3'b000} +: 8];
            default:  dq_o = 8'h00;
        endcase
    end

    assign stb_start = byte_ph && !inflight;
    assign stb_read  = (phase == PH_DATA) && cw_q.rx;
    assign busy      = (phase != PH_IDLE);
    assign cw_out    = cw_q;
    assign set_done  = (phase == PH_WAIT) && rdy;
    assign set_tmo   = (phase == PH_WAIT) && !rdy && (tcnt == tmo_lim);

    // R11
    cw_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && go_req) |=> $stable(cw_q));
    // R2
    no_strobe_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stb_done |-> byte_ph);
endmodule

// File: rtl/nseq_regs.sv
// Register file: holds the programmed command bytes, address, transmit and
// timing words, accepts GO only when idle, keeps the write-one-to-clear
// interrupt bits and muxes read data.
module nseq_regs
    import nseq_pkg::*;
#(
    parameter int STB_W = 4,
    parameter int TMO_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [REG_AW-1:0] reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    input  logic              busy,
    input  logic [31:0]       cw_in,
    input  logic [31:0]       resp,
    input  logic              rdy,
    input  logic              set_done,
    input  logic              set_tmo,
    output logic              go_req,
    output logic [7:0]        cmd1,
    output logic [7:0]        cmd2,
    output logic [31:0]       addr_lo,
    output logic [7:0]        addr_hi,
    output logic [31:0]       tx_word,
    output logic [STB_W-1:0]  we_lo,
    output logic [STB_W-1:0]  we_hi,
    output logic [STB_W-1:0]  re_lo,
    output logic [STB_W-1:0]  re_hi,
    output logic [TMO_W-1:0]  tmo_lim,
    output logic              irq
);
    localparam int TIM_W = 4 * STB_W + TMO_W;

    logic [TIM_W-1:0] timing;
    logic [1:0]       irq_q;
    logic [1:0]       w1c;

    assign go_req = reg_wr && (reg_addr == OFS_CTRL) && reg_wdata[0] && !busy;
    assign w1c    = (reg_wr && reg_addr == OFS_IRQ) ? reg_wdata[1:0] : 2'b00;

    // Store programmed values and update the pending interrupt bits.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            {cmd2, cmd1} <= '0;
            addr_lo      <= '0;
            addr_hi      <= '0;
            tx_word      <= '0;
            timing       <= '0;
            irq_q        <= '0;
        end else begin
            if (reg_wr) begin
                case (reg_addr)
                    OFS_CMDS:   {cmd2, cmd1} <= reg_wdata[15:0];
                    OFS_ADR_LO: addr_lo      <= reg_wdata;
                    OFS_ADR_HI: addr_hi      <= reg_wdata[7:0];
                    OFS_DATA:   tx_word      <= reg_wdata;
                    OFS_TIMING: timing       <= reg_wdata[TIM_W-1:0];
                    default: ;
                endcase
            end
            irq_q <= (irq_q & ~w1c) | {set_tmo, set_done};
        end
    end

    assign {tmo_lim, re_hi, re_lo, we_hi, we_lo} = timing;
    assign irq = |irq_q;

    // Read-back multiplexer.
    always_comb begin
        case (reg_addr)
            OFS_CTRL:   reg_rdata = cw_in | {31'b0, busy};
            OFS_CMDS:   reg_rdata = {16'b0, cmd2, cmd1};
            OFS_ADR_LO: reg_rdata = addr_lo;
            OFS_ADR_HI: reg_rdata = {24'b0, addr_hi};
            OFS_TIMING: reg_rdata = 32'(timing);
            OFS_DATA:   reg_rdata = resp;
            OFS_STATUS: reg_rdata = {31'b0, rdy};
            default:    reg_rdata = {30'b0, irq_q};
        endcase
    end

    // R9
    done_pending_chk: assert property (@(posedge clk) disable iff (!rst_n)
        set_done |=> irq);
    // R12
    tmo_ends_chk: assert property (@(posedge clk) disable iff (!rst_n)
        set_tmo |=> (!busy && irq_q[1]));
endmodule

// File: rtl/nand_seq.sv
// NAND command sequencer top: ties register file, phase sequencer and strobe
// timer together and forms the active-low strobes. Assumes an 8-bit bus with
// one chip enable held by the system.
module nand_seq
    import nseq_pkg::*;
#(
    parameter int STB_W = 4,
    parameter int TMO_W = 16
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        reg_wr,
    input  logic [2:0]  reg_addr,
    input  logic [31:0] reg_wdata,
    output logic [31:0] reg_rdata,
    output logic        irq,
    output logic        nand_cle,
    output logic        nand_ale,
    output logic        nand_we_n,
    output logic        nand_re_n,
    output logic [7:0]  nand_dq_o,
    output logic        nand_dq_oe,
    input  logic [7:0]  nand_dq_i,
    input  logic        nand_rdy
);
    logic             go_req, busy, set_done, set_tmo;
    logic [31:0]      cw_q, resp, addr_lo, tx_word;
    logic [7:0]       cmd1, cmd2, addr_hi;
    logic [STB_W-1:0] we_lo, we_hi, re_lo, re_hi;
    logic [TMO_W-1:0] tmo_lim;
    logic             stb_start, stb_read, stb_low, stb_sample, stb_done;

    nseq_regs #(.STB_W(STB_W), .TMO_W(TMO_W)) i_regs (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .busy(busy), .cw_in(cw_q),
        .resp(resp), .rdy(nand_rdy), .set_done(set_done), .set_tmo(set_tmo),
        .go_req(go_req), .cmd1(cmd1), .cmd2(cmd2), .addr_lo(addr_lo),
        .addr_hi(addr_hi), .tx_word(tx_word), .we_lo(we_lo), .we_hi(we_hi),
        .re_lo(re_lo), .re_hi(re_hi), .tmo_lim(tmo_lim), .irq(irq)
    );

    nseq_fsm #(.TMO_W(TMO_W)) i_fsm (
        .clk(clk), .rst_n(rst_n), .go_req(go_req), .go_word(reg_wdata),
        .cmd1(cmd1), .cmd2(cmd2), .addr_lo(addr_lo), .addr_hi(addr_hi),
        .tx_word(tx_word), .tmo_lim(tmo_lim), .rdy(nand_rdy), .dq_i(nand_dq_i),
        .stb_sample(stb_sample), .stb_done(stb_done), .stb_start(stb_start),
        .stb_read(stb_read), .busy(busy), .cw_out(cw_q), .resp(resp),
        .set_done(set_done), .set_tmo(set_tmo), .cle(nand_cle), .ale(nand_ale),
        .dq_o(nand_dq_o), .dq_oe(nand_dq_oe)
    );

    nseq_strobe #(.CNT_W(STB_W)) i_stb (
        .clk(clk), .rst_n(rst_n), .start(stb_start),
        .lo_cnt(stb_read ? re_lo : we_lo), .hi_cnt(stb_read ? re_hi : we_hi),
        .low(stb_low), .sample(stb_sample), .done(stb_done)
    );

    assign nand_we_n = !(stb_low && !stb_read);
    assign nand_re_n = !(stb_low && stb_read);

    // R13
    latch_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(nand_cle && nand_ale));
    // R13
    strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        nand_we_n || nand_re_n);
endmodule

// File: tb/test_nand_seq.sv
`timescale 1ns/1ps
module test_nand_seq;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [2:0]  reg_addr = 3'd0;
    logic [31:0] reg_wdata = 32'd0;
    logic [31:0] reg_rdata;
    logic        irq, nand_cle, nand_ale, nand_we_n, nand_re_n, nand_dq_oe;
    logic [7:0]  nand_dq_o, nand_dq_i;
    logic        nand_rdy = 1'b1;

    int n_chk = 0;
    int n_fail = 0;

    always #2 clk = ~clk;

    nand_seq i_nand_seq (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq),
        .nand_cle(nand_cle), .nand_ale(nand_ale), .nand_we_n(nand_we_n),
        .nand_re_n(nand_re_n), .nand_dq_o(nand_dq_o), .nand_dq_oe(nand_dq_oe),
        .nand_dq_i(nand_dq_i), .nand_rdy(nand_rdy)
    );

    // Flash model: log latched bytes, feed an incrementing read pattern.
    logic [9:0] log_e [16];
    int log_n = 0;
    int rd_idx = 0;
    assign nand_dq_i = 8'hB0 + 8'(rd_idx);
    always @(posedge nand_we_n) if (log_n < 16) begin
        log_e[log_n] = {nand_cle, nand_ale, nand_dq_o};
        log_n++;
    end
    always @(posedge nand_re_n) rd_idx++;

    // Strobe width monitor.
    int we_run = 0, re_run = 0, exp_we = 3, exp_re = 4, we_bad = 0, re_bad = 0;
    always @(negedge clk) begin
        if (!nand_we_n) we_run++;
        else if (we_run != 0) begin if (we_run != exp_we) we_bad++; we_run = 0; end
        if (!nand_re_n) re_run++;
        else if (re_run != 0) begin if (re_run != exp_re) re_bad++; re_run = 0; end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic wait_idle();
        logic [31:0] v;
        for (int i = 0; i < 3000; i++) begin
            rd(3'd0, v);
            if (!v[0]) break;
        end
    endtask

    // Vectors: {command word, {cmd2, cmd1}, address low, address high}.
    localparam logic [111:0] VECS [7] = '{
        {32'h0000_07E7, 16'h3000, 32'h1234_0820, 32'h0000_0005}, // page read
        {32'h0000_0D67, 16'h1080, 32'h0007_0010, 32'h0000_0001}, // program
        {32'h0000_0417, 16'hD060, 32'h0003_0042, 32'h0000_0000}, // erase, 3 bytes
        {32'h0000_03C7, 16'h0090, 32'h0000_0000, 32'h0000_0000}, // identify
        {32'h0000_00C3, 16'h0070, 32'h0000_0000, 32'h0000_0000}, // status read
        {32'h0000_0003, 16'h00FF, 32'h0000_0000, 32'h0000_0000}, // reset
        {32'h0000_000D, 16'h0000, 32'h0000_A5C3, 32'h0000_0000}  // address only
    };
    localparam logic [31:0] TXW = 32'h4433_2211;

    task automatic run_vec(input logic [111:0] v);
        logic [31:0] cw, a1, a2, got;
        logic [15:0] cb;
        logic [9:0]  ex [16];
        logic [39:0] ab;
        int n;
        cw = v[111:80]; cb = v[79:64]; a1 = v[63:32]; a2 = v[31:0];
        wr(3'd1, {16'b0, cb}); wr(3'd2, a1); wr(3'd3, a2); wr(3'd7, 32'h3);
        log_n = 0; rd_idx = 0;
        wr(3'd0, cw);
        wait_idle();
        ab = {a2[7:0], a1};
        n = 0;
        if (cw[1]) begin ex[n] = {2'b10, cb[7:0]}; n++; end
        if (cw[2]) for (int k = 0; k <= int'(cw[5:3]); k++) begin ex[n] = {2'b01, ab[8*k +: 8]}; n++; end
        if (cw[10] && !cw[11]) begin ex[n] = {2'b10, cb[15:8]}; n++; end
        if (cw[6] && !cw[7]) for (int k = 0; k <= int'(cw[9:8]); k++) begin ex[n] = {2'b00, TXW[8*k +: 8]}; n++; end
        if (cw[10] && cw[11]) begin ex[n] = {2'b10, cb[15:8]}; n++; end
        chk("R2 byte count", 32'(log_n), 32'(n));
        for (int k = 0; k < n && k < log_n; k++)
            chk("R2 R3 R4 R6 latched byte", 32'(log_e[k]), 32'(ex[k]));
        rd(3'd5, got);
        if (cw[6] && cw[7]) begin
            logic [31:0] er = 0;
            for (int k = 0; k <= int'(cw[9:8]); k++) er[8*k +: 8] = 8'hB0 + 8'(k);
            chk("R5 response word", got, er);
        end
        rd(3'd7, got);
        chk("R8 done bit", got, 32'h1);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL R8 watchdog expired: actual hung expected finish");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        logic [31:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        @(negedge clk);
        chk("R1 bus idle", {nand_cle, nand_ale, nand_we_n, nand_re_n, nand_dq_oe, irq}, 32'b001100);
        for (int a = 0; a < 8; a++) begin
            rd(3'(a), v);
            chk("R1 register zero", v, (a == 6) ? 32'h1 : 32'h0);
        end
        // R10 ready mirror
        nand_rdy = 1'b0;
        rd(3'd6, v); chk("R10 status low", v, 32'h0);
        nand_rdy = 1'b1;
        rd(3'd6, v); chk("R10 status high", v, 32'h1);

        wr(3'd4, 32'h0064_0312);
        wr(3'd5, TXW);
        for (int i = 0; i < 7; i++) run_vec(VECS[i]);
        // R7 strobe widths
        chk("R7 write low width", 32'(we_bad), 32'd0);
        chk("R7 read low width", 32'(re_bad), 32'd0);
        wr(3'd4, 32'h0064_1F10);
        exp_we = 1; exp_re = 16;
        run_vec(VECS[4]);
        chk("R7 narrow write width", 32'(we_bad), 32'd0);
        chk("R7 wide read width", 32'(re_bad), 32'd0);

        // R8 wait on ready, R11 GO ignored while busy
        wr(3'd7, 32'h3);
        nand_rdy = 1'b0;
        log_n = 0;
        wr(3'd1, 32'h00FF);
        wr(3'd0, 32'h0000_0003);
        repeat (30) @(negedge clk);
        rd(3'd0, v); chk("R8 GO held while busy", v, 32'h3);
        rd(3'd7, v); chk("R8 no done while busy", v, 32'h0);
        wr(3'd0, 32'h0000_00C3);
        rd(3'd0, v); chk("R11 command word unchanged", v, 32'h3);
        nand_rdy = 1'b1;
        wait_idle();
        rd(3'd0, v); chk("R8 GO cleared", v, 32'h2);
        rd(3'd7, v); chk("R8 done set", v, 32'h1);
        chk("R11 no second command ran", 32'(log_n), 32'd1);
        // R9 interrupt output and clear
        chk("R9 irq high", 32'(irq), 32'd1);
        wr(3'd7, 32'h1);
        @(negedge clk);
        chk("R9 irq cleared", 32'(irq), 32'd0);
        rd(3'd7, v); chk("R9 bits cleared", v, 32'h0);

        // R12 timeout
        wr(3'd4, 32'h0014_0312);
        nand_rdy = 1'b0;
        wr(3'd0, 32'h0000_0003);
        repeat (60) @(negedge clk);
        rd(3'd0, v); chk("R12 command ended", 32'(v[0]), 32'd0);
        rd(3'd7, v); chk("R12 timeout bit only", v, 32'h2);
        nand_rdy = 1'b1;

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule